// File: doc/BRIEF.md
# Write-Update Home Controller

This block sits at the home node of one shared datum and makes writes to it atomic across every cached copy, using an update protocol in place of invalidation. A processor sends a write request carrying the new data word and its own node index. The controller locks the central copy and tells every sharer in the directory mask to stop serving reads of its copy. It then sends the new word to the sharers one at a time and waits for each acknowledgement. Each copy becomes readable again as soon as it has been refreshed.

When the last sharer has acknowledged, the central copy takes the new value and is unlocked. In the following cycle the writer receives a completion pulse. Any write that arrives while a transaction is in progress is turned away with a retry response in the same cycle. The sharer set comes from the directory on `sharer_mask` and is captured when the write is accepted. Bit i of every per-sharer vector refers to sharer node i.

Top module: `wupd_home_ctrl`

## Requirements
- R1: After reset, or while `rst_n` is low, `home_locked`, `wr_done`, `wr_retry` (with `wr_req` low), `blk_req`, `upd_valid` and `unblk` are all zero and `home_data` is zero.
- R2: A write accepted while the controller is idle raises `home_locked` in the next cycle, and `home_locked` stays high until every sharer in the captured mask has acknowledged its update.
- R3: `blk_req` equals the captured sharer mask for exactly one cycle, and that cycle comes before any update is sent.
- R4: Updates are sent one at a time in ascending sharer index. `upd_valid` is one-hot or zero, `upd_data` carries the accepted write data, and each sharer in the mask is updated exactly once.
- R5: No further update is sent until the sharer currently being updated raises its own bit of `upd_ack`. Ack bits from other sharers have no effect.
- R6: `unblk` pulses the bit of a sharer in the cycle after that sharer's accepted ack, and at no other time.
- R7: `home_data` keeps its old value while `home_locked` is high. It shows the new write data from the first cycle in which `home_locked` is low again.
- R8: `wr_done` is high for one cycle, in the first cycle with `home_locked` low after the transaction. In that cycle `wr_done_node` equals the writer's node index.
- R9: A `wr_req` seen while the controller is busy makes `wr_retry` high in the same cycle. It changes neither the updates sent nor the final central value.
- R10: With an empty sharer mask the write completes with no read-block, update or unblock message, and the central copy still takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request valid |
| wr_node | input | IDX_W | Index of the writing node |
| wr_data | input | DATA_W | Data word to write |
| sharer_mask | input | N_SHARERS | Nodes holding a cached copy, captured on accept |
| wr_retry | output | 1 | Request refused because a write is in progress |
| wr_done | output | 1 | Write complete, one-cycle pulse |
| wr_done_node | output | IDX_W | Node being acknowledged |
| blk_req | output | N_SHARERS | Read-block message per sharer |
| upd_valid | output | N_SHARERS | Update message, one-hot |
| upd_data | output | DATA_W | Data word carried by the update |
| upd_ack | input | N_SHARERS | Update acknowledgement per sharer |
| unblk | output | N_SHARERS | Read re-enable per sharer |
| home_locked | output | 1 | Central copy locked |
| home_data | output | DATA_W | Central copy of the datum |

## Verification
The assertions take for granted that a sharer raises `upd_ack` only for an update it has actually received, and for one cycle, so that every `unblk` pulse can be traced to an ack in the cycle before. The bench's sharer model keeps to this rule. It raises the expected bit only in the waiting phase and only once per update. Stray acks appear only on other sharers' bits, and the design must ignore those. The bench drops `wr_req` after a single accepted cycle, and it sends retry probes only while a transaction is in flight.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOCK   = 3'd1,
      ST_BLOCK  = 3'd2,
      ST_UPD    = 3'd3,
      ST_WAIT   = 3'd4,
      ST_UNLOCK = 3'd5,
      ST_DONE   = 3'd6
   } wupd_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wupd_pick.sv
// Lowest-index-first selector over the still-pending sharers.
module wupd_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant_oh,
   output logic         any
);
   logic [N:0] below;

   assign below[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign below[i+1]  = below[i] | req[i];
         assign grant_oh[i] = req[i] & ~below[i];
      end
   endgenerate

   assign any = below[N];
endmodule

// File: rtl/wupd_sharer_track.sv
// Keeps the set of sharers still awaiting an update and forms the
// per-sharer block / unblock messages.
module wupd_sharer_track #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] load_mask,
   input  logic         do_block,
   input  logic         issue,
   input  logic [N-1:0] grant_oh,
   input  logic         wait_active,
   input  logic [N-1:0] ack_in,
   output logic [N-1:0] pending,
   output logic [N-1:0] blk_req,
   output logic [N-1:0] unblk,
   output logic         ack_hit
);
   logic [N-1:0] cur_oh;
   logic [N-1:0] unblk_q;

   assign ack_hit = wait_active & (|(ack_in & cur_oh));
   assign blk_req = do_block ? pending : '0;
   assign unblk   = unblk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         cur_oh  <= '0;
         unblk_q <= '0;
      end else begin
         if (load) begin
            pending <= load_mask;
         end else if (ack_hit) begin
            pending <= pending & ~cur_oh;
         end

         if (issue) begin
            cur_oh <= grant_oh;
         end else if (ack_hit) begin
            cur_oh <= '0;
         end

         unblk_q <= ack_hit ? cur_oh : '0;
      end
   end
endmodule

// File: rtl/wupd_fsm.sv
// Transaction sequencer: lock, block all, update each, unlock, done.
module wupd_fsm
   import wupd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req,
   input  logic pend_any,
   input  logic ack_hit,
   output logic load,
   output logic do_block,
   output logic issue,
   output logic wait_active,
   output logic commit,
   output logic locked,
   output logic done,
   output logic busy
);
   wupd_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (wr_req) st_d = ST_LOCK;
         ST_LOCK:   st_d = ST_BLOCK;
         ST_BLOCK:  st_d = ST_UPD;
         ST_UPD:    st_d = pend_any ? ST_WAIT : ST_UNLOCK;
         ST_WAIT:   if (ack_hit) st_d = ST_UPD;
         ST_UNLOCK: st_d = ST_DONE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign busy        = (st_q != ST_IDLE);
   assign load        = (st_q == ST_IDLE) & wr_req;
   assign do_block    = (st_q == ST_BLOCK);
   assign issue       = (st_q == ST_UPD) & pend_any;
   assign wait_active = (st_q == ST_WAIT);
   assign commit      = (st_q == ST_UNLOCK);
   assign done        = (st_q == ST_DONE);
   assign locked      = (st_q == ST_LOCK) | (st_q == ST_BLOCK) |
                        (st_q == ST_UPD)  | (st_q == ST_WAIT)  |
                        (st_q == ST_UNLOCK);
endmodule

// File: rtl/wupd_home_ctrl.sv
module wupd_home_ctrl #(
   parameter int N_SHARERS = 4,
   parameter int DATA_W    = 16,
   parameter int IDX_W     = wupd_pkg::idx_width(N_SHARERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_req,
   input  logic [IDX_W-1:0]     wr_node,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [N_SHARERS-1:0] sharer_mask,
   output logic                 wr_retry,
   output logic                 wr_done,
   output logic [IDX_W-1:0]     wr_done_node,
   output logic [N_SHARERS-1:0] blk_req,
   output logic [N_SHARERS-1:0] upd_valid,
   output logic [DATA_W-1:0]    upd_data,
   input  logic [N_SHARERS-1:0] upd_ack,
   output logic [N_SHARERS-1:0] unblk,
   output logic                 home_locked,
   output logic [DATA_W-1:0]    home_data
);
   initial begin
      assert (N_SHARERS >= 1) else $fatal(1, "N_SHARERS must be at least 1");
      assert (DATA_W >= 1)    else $fatal(1, "DATA_W must be at least 1");
      assert ((1 << IDX_W) >= N_SHARERS) else $fatal(1, "IDX_W too narrow");
   end

   logic                 load, do_block, issue, wait_active, commit, busy;
   logic                 pend_any, ack_hit;
   logic [N_SHARERS-1:0] pending, grant_oh;
   logic [DATA_W-1:0]    data_q, home_q;
   logic [IDX_W-1:0]     node_q;

   wupd_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (wr_req),
      .pend_any    (pend_any),
      .ack_hit     (ack_hit),
      .load        (load),
      .do_block    (do_block),
      .issue       (issue),
      .wait_active (wait_active),
      .commit      (commit),
      .locked      (home_locked),
      .done        (wr_done),
      .busy        (busy)
   );

   wupd_pick #(.N(N_SHARERS)) u_pick (
      .req      (pending),
      .grant_oh (grant_oh),
      .any      (pend_any)
   );

   wupd_sharer_track #(.N(N_SHARERS)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .load_mask   (sharer_mask),
      .do_block    (do_block),
      .issue       (issue),
      .grant_oh    (grant_oh),
      .wait_active (wait_active),
      .ack_in      (upd_ack),
      .pending     (pending),
      .blk_req     (blk_req),
      .unblk       (unblk),
      .ack_hit     (ack_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         node_q <= '0;
         home_q <= '0;
      end else begin
         if (load) begin
            data_q <= wr_data;
            node_q <= wr_node;
         end
         if (commit) begin
            home_q <= data_q;
         end
      end
   end

   assign wr_retry     = wr_req & busy;
   assign upd_valid    = issue ? grant_oh : '0;
   assign upd_data     = data_q;
   assign wr_done_node = node_q;
   assign home_data    = home_q;
endmodule

// File: rtl/wupd_home_ctrl_chk.sv
module wupd_home_ctrl_chk #(
   parameter int N_SHARERS = 4,
   parameter int DATA_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_req,
   input logic                 wr_retry,
   input logic                 wr_done,
   input logic [N_SHARERS-1:0] blk_req,
   input logic [N_SHARERS-1:0] upd_valid,
   input logic [N_SHARERS-1:0] upd_ack,
   input logic [N_SHARERS-1:0] unblk,
   input logic                 home_locked,
   input logic [DATA_W-1:0]    home_data
);
   a_r2_lock_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(home_locked) |-> $past(wr_req));

   a_r3_block_before_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (|blk_req) |-> (upd_valid == '0));

   a_r4_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_valid));

   a_r6_unblk_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (|unblk) |-> $past(|upd_ack));

   a_r6_unblk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unblk));

   a_r7_home_changes_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(home_data) |-> wr_done);

   a_r8_done_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (!home_locked && $past(home_locked)));

   a_r9_retry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      wr_retry |-> wr_req);
endmodule

bind wupd_home_ctrl wupd_home_ctrl_chk #(
   .N_SHARERS (N_SHARERS),
   .DATA_W    (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_req      (wr_req),
   .wr_retry    (wr_retry),
   .wr_done     (wr_done),
   .blk_req     (blk_req),
   .upd_valid   (upd_valid),
   .upd_ack     (upd_ack),
   .unblk       (unblk),
   .home_locked (home_locked),
   .home_data   (home_data)
);

// File: tb/wupd_home_ctrl_tb.sv
`timescale 1ns/1ps
module wupd_home_ctrl_tb;
   localparam int N  = 4;
   localparam int DW = 16;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [IW-1:0] wr_node = '0;
   logic [DW-1:0] wr_data = '0;
   logic [N-1:0]  sharer_mask = '0;
   logic          wr_retry, wr_done;
   logic [IW-1:0] wr_done_node;
   logic [N-1:0]  blk_req, upd_valid, unblk;
   logic [N-1:0]  upd_ack = '0;
   logic [DW-1:0] upd_data, home_data;
   logic          home_locked;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   logic [DW-1:0] exp_home = '0;

   always #4 clk = ~clk;   // 125 MHz

   wupd_home_ctrl #(.N_SHARERS(N), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_node(wr_node),
      .wr_data(wr_data), .sharer_mask(sharer_mask), .wr_retry(wr_retry),
      .wr_done(wr_done), .wr_done_node(wr_done_node), .blk_req(blk_req),
      .upd_valid(upd_valid), .upd_data(upd_data), .upd_ack(upd_ack),
      .unblk(unblk), .home_locked(home_locked), .home_data(home_data)
   );

   // vector: [27:24] mask, [23:8] data, [7:4] ack delay, [3:0] writer node
   localparam int NV = 6;
   localparam logic [27:0] VEC [0:NV-1] = '{
      {4'b1011, 16'hA5A5, 4'd0, 4'd2},
      {4'b0000, 16'h1234, 4'd0, 4'd1},
      {4'b1111, 16'hFFFF, 4'd3, 4'd0},
      {4'b1000, 16'h0F0F, 4'd1, 4'd3},
      {4'b0100, 16'h7777, 4'd2, 4'd1},
      {4'b0110, 16'h5A5A, 4'd0, 4'd3}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int lowest(input logic [N-1:0] m);
      for (int i = 0; i < N; i++) if (m[i]) return i;
      return -1;
   endfunction

   task automatic run_write(input logic [N-1:0] mask, input logic [DW-1:0] data,
                            input int delay, input logic [IW-1:0] node);
      logic [N-1:0] remaining = mask;
      logic [N-1:0] blk_seen  = '0;
      logic [N-1:0] exp_unblk = '0;
      logic [N-1:0] cur_oh    = '0;
      bit   waiting = 0, got_upd = 0, finished = 0, prev_locked = 1;
      int   cnt = 0, guard = 0;
      logic [DW-1:0] old_home = exp_home;

      @(negedge clk);
      wr_req = 1'b1; wr_node = node; wr_data = data; sharer_mask = mask;
      @(posedge clk);
      @(negedge clk);
      wr_req = 1'b0;
      // R2: lock raised the cycle after acceptance
      chk(home_locked == 1'b1, "R2", "lock after accept", home_locked, 1);
      // R9: probe with a foreign write while busy, held across one edge
      wr_req = 1'b1; wr_data = ~data; wr_node = ~node; sharer_mask = ~mask;
      #1;
      chk(wr_retry == 1'b1, "R9", "retry while busy", wr_retry, 1);
      @(negedge clk);
      wr_req = 1'b0;
      prev_locked = home_locked;
      while (!finished && guard < 300) begin
         guard++;
         // ---- sample ----
         if (blk_req != '0) begin
            chk(blk_req == mask, "R3", "block mask", blk_req, mask);
            chk(!got_upd && blk_seen == '0, "R3", "block before update", got_upd, 0);
            blk_seen = blk_seen | blk_req;
         end
         if (upd_valid != '0) begin
            chk(!waiting, "R5", "update while previous unacked", upd_valid, 0);
            chk(lowest(upd_valid) == lowest(remaining) && $onehot(upd_valid),
                "R4", "update order", upd_valid, 1 << lowest(remaining));
            chk(upd_data == data, "R9", "update carries accepted data", upd_data, data);
            chk(blk_seen == mask, "R3", "blocked before update", blk_seen, mask);
            got_upd = 1; cur_oh = upd_valid; remaining = remaining & ~upd_valid;
            waiting = 1; cnt = 0;
         end
         if (unblk != '0 || exp_unblk != '0)
            chk(unblk == exp_unblk, "R6", "unblock after ack", unblk, exp_unblk);
         if (home_locked)
            if (home_data != old_home)
               chk(0, "R7", "central held while locked", home_data, old_home);
         if (wr_done) begin
            chk(!home_locked && prev_locked, "R8", "done after unlock", home_locked, 0);
            chk(wr_done_node == node, "R8", "done node", wr_done_node, node);
            chk(home_data == data, "R7", "central takes new value", home_data, data);
            chk(remaining == '0 && !waiting, "R2", "all updated before unlock",
                remaining, 0);
            if (mask == '0)
               chk(blk_seen == '0 && !got_upd, "R10", "no messages for empty set",
                   blk_seen, 0);
            finished = 1;
         end
         prev_locked = home_locked;
         // ---- drive ----
         exp_unblk = '0;
         upd_ack   = '0;
         if (waiting && !(upd_valid != '0)) begin
            if (cnt == delay) begin
               upd_ack   = cur_oh;
               exp_unblk = cur_oh;
               waiting   = 0;
            end else begin
               upd_ack = ~cur_oh;  // R5: stray acks from other sharers
            end
            cnt++;
         end
         @(negedge clk);
      end
      upd_ack = '0;
      chk(finished == 1, "R8", "write completed", finished, 1);
      if (finished) begin
         // R8: one-cycle pulse
         chk(wr_done == 1'b0, "R8", "done is a single pulse", wr_done, 0);
         exp_home = data;
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(home_locked == 0 && wr_done == 0 && wr_retry == 0, "R1",
          "reset control", {home_locked, wr_done, wr_retry}, 0);
      chk(blk_req == 0 && upd_valid == 0 && unblk == 0, "R1", "reset messages",
          {blk_req, upd_valid, unblk}, 0);
      chk(home_data == 0, "R1", "reset central", home_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++)
         run_write(VEC[v][27:24], VEC[v][23:8], int'(VEC[v][7:4]), VEC[v][IW-1:0]);

      // R10: empty sharer set, directed
      run_write(4'b0000, 16'hC3C3, 0, 2'd0);

      // R1: reset in mid-transaction
      @(negedge clk);
      wr_req = 1'b1; wr_data = 16'hBEEF; sharer_mask = 4'b0011; wr_node = 2'd1;
      @(negedge clk);
      wr_req = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(home_locked == 0 && upd_valid == 0 && blk_req == 0 && unblk == 0,
          "R1", "async reset clears transaction", {home_locked, upd_valid}, 0);
      chk(home_data == 0, "R1", "reset clears central", home_data, 0);
      exp_home = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_write(4'b0101, 16'h600D, 1, 2'd2);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule